// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM that has a single shared bidirectional data bus. The host offers one read or write at a time over a request/ready handshake. The controller then drives the active-low chip enable, output enable and write enable strobes, together with a 15-bit address. It also drives a write-data bus and a separate driver-enable signal that stands in for the tristate buffer on the board. Every strobe, the address and the driver enable come straight from flops, so they only change on a rising clock edge.

The number of cycles spent in each phase is worked out at elaboration time. The memory's limits are given in nanoseconds, and each one is rounded up to whole periods of the clock-period parameter. The limits are: address access, output-enable access, read cycle, write pulse, data setup, address-to-end-of-write and write cycle. The defaults are a 10 ns clock and the faster 55 ns memory grade, which gives a 6-cycle read access and a 4-cycle write pulse.

The controller is a six-state machine:
- IDLE waits for a request. A read request goes to RD_ACC; a write request goes to WR_SETUP.
- RD_ACC holds chip enable and output enable low until the access timer expires. On that edge it captures the read data and moves to RD_DONE.
- RD_DONE is a bus-idle cycle that returns to IDLE.
- WR_SETUP drives chip enable low with the address and moves to WR_PULSE.
- WR_PULSE holds write enable low with the data driver on until its timer expires, then moves to WR_DONE.
- WR_DONE releases all strobes and returns to IDLE.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, until the first accepted request, all three strobes are high, the data driver is off, `rvalid` is low and `ready` is high.
- R2: A read drives `ce_n`=0, `oe_n`=0 and `we_n`=1 for exactly RD_CYC cycles. On the edge RD_CYC cycles after the accepting edge, `rdata` takes the memory's data and `rvalid` goes high for exactly one cycle.
- R3: On the capture edge, `oe_n` and `ce_n` rise together. One cycle with all strobes high follows, and only then does `ready` return.
- R4: A write spends one cycle with `ce_n`=0 and `we_n`=1. Then `we_n` is low for exactly WP_CYC cycles, with `oe_n` high throughout. `ready` returns WP_CYC+2 cycles after the accepting edge.
- R5: The data driver enable is high exactly while `we_n` is low, and the driven data holds the request's write data, unchanged, for the whole pulse.
- R6: The memory address is taken from the request on the accepting edge and stays unchanged while chip enable is low.
- R7: `ready` is high only while the controller is idle, and a request is taken only on an edge where `ready` is high.
- R8: The data driver is never on while the memory's outputs are enabled, nor in the cycle after `oe_n` rises.
- R9: RD_CYC is the largest of the rounded-up address access, output-enable access and read cycle times. WP_CYC is the largest of: the rounded-up write pulse, the rounded-up data setup, the rounded-up address-to-end-of-write minus one, and the rounded-up write cycle minus two. With the defaults these are 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle, request may be taken |
| rvalid | output | 1 | One-cycle pulse: rdata holds read result |
| rdata | output | 8 | Captured read data |
| sram_addr | output | 15 | Memory address |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Driver enable for sram_dq_o |
| sram_dq_i | input | 8 | Data read from the memory bus |

## Verification
Two things can fall on the same clock edge: the end of a read (capture of the data and release of output enable) and the start of the next transaction. They collide when the host issues a write in the first cycle `ready` returns after a read. The bench provokes this by issuing each request in the same half-cycle that `ready` is seen high. A bus model counts any cycle where the controller drives while the memory could still be driving, and any cycle directly after output enable rises. That count must stay at zero, and the readback that follows must return the written byte. The memory model returns garbage until the access time in cycles has elapsed, and it corrupts writes whose pulse is too short. As a result, a capture made one edge early, or a pulse that is one cycle short, shows up as a data mismatch.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_DONE
    } state_e;

    // Round a nanosecond limit up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R9: a running count steps down by one per cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // R2: read-valid is a single-cycle pulse
    p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |=> !rvalid_q);

    // R6: the held address changes only on an accepted request
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 10,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 30,
    parameter int T_RC_NS = 55,
    parameter int T_WP_NS = 40,
    parameter int T_DW_NS = 25,
    parameter int T_AW_NS = 50,
    parameter int T_WC_NS = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    // R9: phase lengths in cycles, derived from the nanosecond limits
    localparam int RD_RAW = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                 ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int RD_CYC = imax(RD_RAW, 1);
    localparam int WP_RAW = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_AW_NS, CLK_NS) - 1,
                                      ns_to_cyc(T_WC_NS, CLK_NS) - 2));
    localparam int WP_CYC = imax(WP_RAW, 1);
    localparam int CNT_W  = $clog2(imax(RD_CYC, WP_CYC)) + 1;
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

    state_e           state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && req;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_addr   (addr),
        .in_wdata  (wdata),
        .capture   (capture),
        .mem_rdata (sram_dq_i),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_o),
        .rdata_q   (rdata),
        .rvalid_q  (rvalid)
    );

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (we) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    state_d = ST_RD_DONE;
                end
            end
            ST_RD_DONE: state_d = ST_IDLE;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d = ST_WR_DONE;
                end
            end
            ST_WR_DONE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobes, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            ready      <= 1'b1;
        end else begin
            sram_ce_n  <= !(state_d == ST_RD_ACC || state_d == ST_WR_SETUP ||
                            state_d == ST_WR_PULSE);
            sram_oe_n  <= (state_d != ST_RD_ACC);
            sram_we_n  <= (state_d != ST_WR_PULSE);
            sram_dq_oe <= (state_d == ST_WR_PULSE);
            ready      <= (state_d == ST_IDLE);
        end
    end

    // R1, R7: while ready the memory bus is fully released
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    // R4: output enable stays high during the write pulse
    p_oe_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    // R5: driver enable tracks the write pulse
    p_drv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe == !sram_we_n);

    // R5: driven data stays put within a pulse
    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_dq_o));

    // R8: no drive in the cycle after output enable was low
    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sram_oe_n) |-> !sram_dq_oe);

    // R3: read result appears with the strobes already released
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (sram_ce_n && sram_oe_n && !ready));

    // R6: address is steady while the chip stays enabled
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

    localparam int RD_NEED = 6;            // 55 ns at 10 ns, rounded up
    localparam int WP_NEED = 4;            // from 40/25/50-10/55-20 ns
    localparam int RD_LAT  = RD_NEED + 1;  // negedges from accept to rvalid
    localparam int WR_LAT  = WP_NEED + 3;  // negedges from accept to ready
    localparam int NVEC    = 12;

    // {we, addr, data}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'h3C},
        {1'b0, 15'h0000, 8'hA5}, {1'b0, 15'h7FFF, 8'h5A}, {1'b1, 15'h0000, 8'hC3},
        {1'b0, 15'h1234, 8'h3C}, {1'b0, 15'h0000, 8'hC3}, {1'b1, 15'h4000, 8'hFF},
        {1'b0, 15'h4000, 8'hFF}, {1'b1, 15'h0001, 8'h00}, {1'b0, 15'h0001, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic [14:0] sram_addr;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [7:0]  dq_o;
    logic [7:0]  dq_i = 8'hEE;

    int n_cmp = 0;
    int n_mis = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rvalid(rvalid), .rdata(rdata), .sram_addr(sram_addr),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
        .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Cycle-level memory model
    logic [7:0]  mem [logic [14:0]];
    int          rd_age = 0, wp_age = 0, last_wp = 0, conflicts = 0;
    logic        prev_rd = 1'b0, prev_wr = 1'b0, prev_oe_n = 1'b1;
    logic        rd_act, wr_act;
    logic [14:0] prev_addr = '0, w_addr = '0;
    logic [7:0]  w_dat = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_age = 0; wp_age = 0; prev_rd = 1'b0; prev_wr = 1'b0; prev_oe_n = 1'b1;
            dq_i = 8'hEE;
        end else begin
            rd_act = (ce_n === 1'b0) && (oe_n === 1'b0) && (we_n === 1'b1);
            wr_act = (ce_n === 1'b0) && (we_n === 1'b0) && (dq_oe === 1'b1);
            if (rd_act && prev_rd && sram_addr == prev_addr) rd_age++;
            else rd_age = rd_act ? 1 : 0;
            if (rd_act && rd_age >= RD_NEED)
                dq_i = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
            else
                dq_i = 8'hEE;
            if (dq_oe === 1'b1 && (rd_act || prev_oe_n === 1'b0)) conflicts++;
            if (wr_act) begin
                if (prev_wr && sram_addr == w_addr && dq_o == w_dat) wp_age++;
                else wp_age = 1;
                w_addr = sram_addr;
                w_dat  = dq_o;
            end else if (prev_wr) begin
                last_wp = wp_age;
                mem[w_addr] = (wp_age >= WP_NEED) ? w_dat : 8'hBD;
            end
            prev_rd   = rd_act;
            prev_wr   = wr_act;
            prev_addr = sram_addr;
            prev_oe_n = oe_n;
        end
    end

    task automatic txn(input logic w, input logic [14:0] a, input logic [7:0] d);
        int n;
        n = 0;
        while (ready !== 1'b1 && n < 50) begin
            @(negedge clk);
            n++;
        end
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (n < 40) begin
            if (n == 3) begin
                chk("R7 ready low while busy", ready, 0);
                chk("R6 address held", sram_addr, a);
                if (w) begin
                    chk("R4 strobes in pulse {ce,oe,we}", {ce_n, oe_n, we_n}, 3'b010);
                    chk("R5 driver on", dq_oe, 1);
                    chk("R5 driven data", dq_o, d);
                end else begin
                    chk("R2 strobes in access {ce,oe,we}", {ce_n, oe_n, we_n}, 3'b001);
                    chk("R5 driver off in read", dq_oe, 0);
                end
            end
            if (w ? (ready === 1'b1) : (rvalid === 1'b1)) break;
            @(negedge clk);
            n++;
        end
        if (w) begin
            chk("R4 R9 write ready latency", n, WR_LAT);
            chk("R4 R9 pulse length", last_wp, WP_NEED);
        end else begin
            chk("R2 R9 read latency", n, RD_LAT);
            chk("R2 read data", rdata, d);
            chk("R3 strobes released at capture", {ce_n, oe_n, ready}, 3'b110);
            @(negedge clk);
            chk("R2 rvalid single cycle", rvalid, 0);
            chk("R3 ready after idle cycle", ready, 1);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a request held during reset
        req = 1'b1; we = 1'b0; addr = 15'h0ABC;
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
        chk("R1 ready in reset", {ready, rvalid}, 2'b10);
        req = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 strobes after reset", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
        chk("R1 ready after reset", {ready, rvalid}, 2'b10);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            txn(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);
        end

        // R2: unwritten location reads as model default
        txn(1'b0, 15'h2AAA, 8'h00);

        // R8: write issued the first cycle ready returns after a read
        txn(1'b0, 15'h4000, 8'hFF);
        txn(1'b1, 15'h4000, 8'h81);
        txn(1'b0, 15'h4000, 8'h81);
        txn(1'b1, 15'h7FFE, 8'h7E);
        txn(1'b1, 15'h7FFE, 8'hE7);
        txn(1'b0, 15'h7FFE, 8'hE7);
        chk("R8 bus conflict cycles", conflicts, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule